// File: doc/BRIEF.md
# DMA Address Translation Unit

This block converts a DMA address issued by a device into a physical memory address. Software programs two 64-bit registers through a small register window. The control register switches translation on, picks the table granule and gives the table size. The base register holds the start address of the translation table in memory.

For each request with translation switched on, the unit forms a table-entry address from the base register and a slice of the device address. It sends one read to memory, takes back a 64-bit entry stored most-significant byte first, and decodes that entry into a physical address, a page-offset mask and an access permission. With translation switched off, the address passes straight through and no memory read is made. A one-cycle done strobe marks each result. Only one request is handled at a time.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, control and base both read as zero, translation is off, req_ready is high, and done and mem_req_valid are low.
- R2: The register window uses byte offsets 0x00 (control) and 0x08 (base). An 8-byte access at the base offset reaches the whole register. A 4-byte access at the base offset reaches bits 63:32, carried in data bits 31:0. A 4-byte access at base offset + 4 reaches bits 31:0. On a 4-byte read, data bits 63:32 read as zero.
- R3: Offsets 0x10 and 0x14 (flush) read as zero and ignore writes. Offsets 0x18 to 0x1F, and any offset whose bits 1:0 are not zero, read as zero and ignore writes.
- R4: When control bit 0 is clear, an accepted request gives done on the next cycle, with phys_addr equal to the device address, page_mask 0x1FFF, perm read-write (2'b11), and no memory read.
- R5: When control bit 0 is set and bit 2 is clear (8K table), with size code n in control bits 18:16, mem_req_addr equals base + ((device address bits (23+n):13) placed at bit 3).
- R6: When control bits 0 and 2 are set (64K table) and n is 0 to 5, mem_req_addr equals base + ((device address bits (26+n):16) placed at bit 3).
- R7: In 64K table mode with n equal to 6 or 7, done follows on the next cycle with perm none (2'b00), phys_addr and page_mask zero, and no memory read.
- R8: mem_rsp_data carries the byte at the lowest memory address in bits 7:0. That byte is bits 63:56 of the entry.
- R9: An entry with bit 63 clear gives perm none (2'b00), with phys_addr and page_mask zero.
- R10: A valid entry with bit 1 set gives perm read-write (2'b11). A valid entry with bit 1 clear gives read-only (2'b01). The value 2'b10 never appears with done.
- R11: A valid entry with bit 61 set gives phys_addr = (entry AND 0x1FFFFFF8000) + device address bits 15:0, and page_mask 0xFFFF. With bit 61 clear, phys_addr = (entry AND 0x1FFFFFFE000) + device address bits 12:0, and page_mask 0x1FFF.
- R12: After a request is accepted, req_ready stays low until done. mem_req_valid is high for exactly one cycle. done follows one cycle after mem_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_size64 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_addr | input | 5 | Byte offset in the register window |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr and reg_size64, combinational |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Unit is idle and accepts a request |
| req_addr | input | 64 | Device DMA address |
| mem_req_valid | output | 1 | Table-entry read request, one-cycle pulse |
| mem_req_addr | output | 64 | Table-entry address |
| mem_rsp_valid | input | 1 | Table-entry data is present |
| mem_rsp_data | input | 64 | Table-entry bytes, lowest address in bits 7:0 |
| done | output | 1 | Result strobe |
| phys_addr | output | 64 | Translated physical address |
| page_mask | output | 64 | Page-offset mask of the result |
| perm | output | 2 | 00 none, 01 read-only, 11 read-write |

## Verification
The assertions check on every cycle the rules that hold whatever is programmed. The perm encoding is never 2'b10. A result with no permission carries zero address and zero mask. A permitted result carries one of the two page masks. The memory request is a single pulse that comes only while the unit is busy, and done follows a response. The values themselves need the bench scenarios to show them: the half-register mapping of 4-byte accesses, the window slice taken for each size code in both table modes, the byte order of the entry, and the physical address formed from entry and offset. These are compared against the bench's own model under random programming and directed corner cases.

// File: rtl/dxu_pkg.sv
package dxu_pkg;
  localparam int WORD_W   = 64;
  localparam int RAW      = 5;
  localparam int CODE_W   = 3;

  // control register fields
  localparam int EN_BIT    = 0;
  localparam int BIGTB_BIT = 2;
  localparam int CODE_LSB  = 16;

  // table entry fields
  localparam int VALID_BIT  = 63;
  localparam int BIGPG_BIT  = 61;
  localparam int WRITE_BIT  = 1;

  localparam logic [WORD_W-1:0] PHYS_KEEP_SMALL = 64'h0000_01FF_FFFF_E000;
  localparam logic [WORD_W-1:0] PHYS_KEEP_BIG   = 64'h0000_01FF_FFFF_8000;
  localparam logic [WORD_W-1:0] OFF_SMALL       = 64'h0000_0000_0000_1FFF;
  localparam logic [WORD_W-1:0] OFF_BIG         = 64'h0000_0000_0000_FFFF;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RO   = 2'b01;
  localparam logic [1:0] PERM_RW   = 2'b11;

  typedef struct packed {
    logic [WORD_W-1:0] phys;
    logic [WORD_W-1:0] pmask;
    logic [1:0]        perm;
  } xres_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } xstate_e;
endpackage

// File: rtl/dxu_regs.sv
module dxu_regs
  import dxu_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = RAW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          size64,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          xl_en,
  output logic          big_tbl,
  output logic [CODE_W-1:0] tbl_code,
  output logic [W-1:0]  base
);
  localparam int HW = W / 2;

  logic [W-1:0] ctrl_q, ctrl_d, base_q, base_d;
  logic         ctrl_en, base_en;
  logic         aligned;
  logic [2:0]   slot;

  assign aligned = (addr[1:0] == 2'b00);
  assign slot    = addr[4:2];

  always_comb begin
    ctrl_d  = ctrl_q;
    base_d  = base_q;
    ctrl_en = 1'b0;
    base_en = 1'b0;
    if (wr_en && aligned) begin
      case (slot)
        3'd0: begin
          ctrl_en = 1'b1;
          if (size64) ctrl_d = wdata;
          else        ctrl_d[W-1:HW] = wdata[HW-1:0];
        end
        3'd1: begin
          ctrl_en = 1'b1;
          ctrl_d[HW-1:0] = wdata[HW-1:0];
        end
        3'd2: begin
          base_en = 1'b1;
          if (size64) base_d = wdata;
          else        base_d[W-1:HW] = wdata[HW-1:0];
        end
        3'd3: begin
          base_en = 1'b1;
          base_d[HW-1:0] = wdata[HW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_comb begin
    rdata = '0;
    if (aligned) begin
      case (slot)
        3'd0: rdata = size64 ? ctrl_q : {{HW{1'b0}}, ctrl_q[W-1:HW]};
        3'd1: rdata = {{HW{1'b0}}, ctrl_q[HW-1:0]};
        3'd2: rdata = size64 ? base_q : {{HW{1'b0}}, base_q[W-1:HW]};
        3'd3: rdata = {{HW{1'b0}}, base_q[HW-1:0]};
        default: rdata = '0;
      endcase
    end
  end

  assign xl_en    = ctrl_q[EN_BIT];
  assign big_tbl  = ctrl_q[BIGTB_BIT];
  assign tbl_code = ctrl_q[CODE_LSB +: CODE_W];
  assign base     = base_q;
endmodule

// File: rtl/dxu_index.sv
module dxu_index
  import dxu_pkg::*;
#(
  parameter int W            = WORD_W,
  parameter int SMALL_TOP0   = 23,
  parameter int BIG_TOP0     = 26,
  parameter int SMALL_LO     = 13,
  parameter int BIG_LO       = 16,
  parameter int ENTRY_BYTES  = 8,
  parameter int BIG_CODE_MAX = 5
) (
  input  logic              big_tbl,
  input  logic [CODE_W-1:0] code,
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      dev_addr,
  output logic [W-1:0]      ent_addr,
  output logic              code_bad
);
  localparam int ENTRY_SH = $clog2(ENTRY_BYTES);
  localparam int SMALL_SH = SMALL_LO - ENTRY_SH;
  localparam int BIG_SH   = BIG_LO - ENTRY_SH;

  logic [W-1:0] keep, hi_mask, lo_mask, offset;
  int top, lo, sh;

  always_comb begin
    if (big_tbl) begin
      top = BIG_TOP0 + int'(code);
      lo  = BIG_LO;
      sh  = BIG_SH;
    end else begin
      top = SMALL_TOP0 + int'(code);
      lo  = SMALL_LO;
      sh  = SMALL_SH;
    end
    hi_mask  = {W{1'b1}} >> (W - 1 - top);
    lo_mask  = {W{1'b1}} << lo;
    keep     = hi_mask & lo_mask;
    offset   = (dev_addr & keep) >> sh;
    ent_addr = base + offset;
    code_bad = big_tbl && (int'(code) > BIG_CODE_MAX);
  end
endmodule

// File: rtl/dxu_decode.sv
module dxu_decode
  import dxu_pkg::*;
(
  input  logic [WORD_W-1:0] bus_word,
  input  logic [WORD_W-1:0] dev_addr,
  output xres_t             res
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] entry;

  for (genvar b = 0; b < NBYTES; b++) begin : g_swap
    assign entry[8*(NBYTES-1-b) +: 8] = bus_word[8*b +: 8];
  end

  always_comb begin
    res = '0;
    if (entry[VALID_BIT]) begin
      res.perm = entry[WRITE_BIT] ? PERM_RW : PERM_RO;
      if (entry[BIGPG_BIT]) begin
        res.pmask = OFF_BIG;
        res.phys  = (entry & PHYS_KEEP_BIG) + (dev_addr & OFF_BIG);
      end else begin
        res.pmask = OFF_SMALL;
        res.phys  = (entry & PHYS_KEEP_SMALL) + (dev_addr & OFF_SMALL);
      end
    end
  end
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_size64,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_addr,
  output logic              mem_req_valid,
  output logic [WORD_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              done,
  output logic [WORD_W-1:0] phys_addr,
  output logic [WORD_W-1:0] page_mask,
  output logic [1:0]        perm
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              xl_en, big_tbl, code_bad;
  logic [CODE_W-1:0] tbl_code;
  logic [WORD_W-1:0] base, ent_addr;
  xres_t             dec_res;

  dxu_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_valid && reg_write),
    .size64   (reg_size64),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .xl_en    (xl_en),
    .big_tbl  (big_tbl),
    .tbl_code (tbl_code),
    .base     (base)
  );

  dxu_index u_index (
    .big_tbl  (big_tbl),
    .code     (tbl_code),
    .base     (base),
    .dev_addr (req_addr),
    .ent_addr (ent_addr),
    .code_bad (code_bad)
  );

  xstate_e           state_q, state_d;
  logic [WORD_W-1:0] addr_q, eaddr_q;
  xres_t             res_q, res_d;
  logic              done_q, done_d;
  logic              addr_en, eaddr_en, res_en;

  dxu_decode u_decode (
    .bus_word (mem_rsp_data),
    .dev_addr (addr_q),
    .res      (dec_res)
  );

  always_comb begin
    state_d  = state_q;
    res_d    = res_q;
    done_d   = 1'b0;
    addr_en  = 1'b0;
    eaddr_en = 1'b0;
    res_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_en = 1'b1;
          if (!xl_en) begin
            res_en     = 1'b1;
            done_d     = 1'b1;
            res_d.phys  = req_addr;
            res_d.pmask = OFF_SMALL;
            res_d.perm  = PERM_RW;
          end else if (code_bad) begin
            res_en = 1'b1;
            done_d = 1'b1;
            res_d  = '0;
          end else begin
            eaddr_en = 1'b1;
            state_d  = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          res_en  = 1'b1;
          done_d  = 1'b1;
          res_d   = dec_res;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   addr_q <= '0;
    else if (addr_en) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    eaddr_q <= '0;
    else if (eaddr_en) eaddr_q <= ent_addr;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign mem_req_addr  = eaddr_q;
  assign done          = done_q;
  assign phys_addr     = res_q.phys;
  assign page_mask     = res_q.pmask;
  assign perm          = res_q.perm;
endmodule

// File: rtl/dxu_checker.sv
module dxu_checker
  import dxu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic [WORD_W-1:0] phys_addr,
  input logic [WORD_W-1:0] page_mask,
  input logic [1:0]        perm
);
  p_perm_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (perm != 2'b10));

  p_none_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && perm == PERM_NONE) |-> (phys_addr == '0 && page_mask == '0));

  p_mask_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && perm != PERM_NONE) |-> (page_mask == OFF_SMALL || page_mask == OFF_BIG));

  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_busy_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_done_after_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready && !mem_req_valid) |=> done);
endmodule

bind dma_xlate_unit dxu_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .done          (done),
  .phys_addr     (phys_addr),
  .page_mask     (page_mask),
  .perm          (perm)
);

// File: tb/tb_dma_xlate_unit.sv
module tb_dma_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write, reg_size64;
  logic [4:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        req_valid, req_ready;
  logic [63:0] req_addr;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        done;
  logic [63:0] phys_addr, page_mask;
  logic [1:0]  perm;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 0;
  logic [63:0] sh_ctrl, sh_base;

  always #2 clk = ~clk;

  dma_xlate_unit dut (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // expected read value of the register window
  function automatic logic [63:0] exp_rd(logic [4:0] a, bit s64);
    logic [63:0] r = '0;
    if (a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: r = s64 ? sh_ctrl : {32'h0, sh_ctrl[63:32]};
        3'd1: r = {32'h0, sh_ctrl[31:0]};
        3'd2: r = s64 ? sh_base : {32'h0, sh_base[63:32]};
        3'd3: r = {32'h0, sh_base[31:0]};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic reg_wr(logic [4:0] a, bit s64, logic [63:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_size64 = s64; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
    if (a[1:0] == 2'b00) begin
      case (a[4:2])
        3'd0: if (s64) sh_ctrl = d; else sh_ctrl[63:32] = d[31:0];
        3'd1: sh_ctrl[31:0] = d[31:0];
        3'd2: if (s64) sh_base = d; else sh_base[63:32] = d[31:0];
        3'd3: sh_base[31:0] = d[31:0];
        default: ;
      endcase
    end
  endtask

  task automatic reg_chk(string tag, logic [4:0] a, bit s64);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_size64 = s64; reg_addr = a;
    #1;
    check(tag, reg_rdata, exp_rd(a, s64));
    reg_valid = 0;
  endtask

  function automatic logic [63:0] exp_eaddr(logic [63:0] a);
    int n = int'(sh_ctrl[18:16]);
    logic [63:0] field;
    logic [63:0] m = (64'd1 << (11 + n)) - 64'd1;
    if (sh_ctrl[2]) field = (a >> 16) & m;
    else            field = (a >> 13) & m;
    return sh_base + (field << 3);
  endfunction

  function automatic logic [63:0] to_bus(logic [63:0] e);
    logic [63:0] w;
    for (int b = 0; b < 8; b++) w[8*b +: 8] = e[8*(7-b) +: 8];
    return w;
  endfunction

  task automatic xlate(string tag, logic [63:0] a, logic [63:0] e, int lat);
    logic [63:0] xp, xm;
    logic [1:0]  xr;
    bit          fetch;
    fetch = sh_ctrl[0] && !(sh_ctrl[2] && sh_ctrl[18:16] > 3'd5);
    if (!sh_ctrl[0]) begin
      xp = a; xm = 64'h1FFF; xr = 2'b11;                      // R4
    end else if (!fetch) begin
      xp = '0; xm = '0; xr = 2'b00;                           // R7
    end else if (!e[63]) begin
      xp = '0; xm = '0; xr = 2'b00;                           // R9
    end else begin
      xr = e[1] ? 2'b11 : 2'b01;                              // R10
      if (e[61]) begin xm = 64'hFFFF; xp = (e & 64'h1FF_FFFF_8000) + {48'h0, a[15:0]}; end
      else       begin xm = 64'h1FFF; xp = (e & 64'h1FF_FFFF_E000) + {51'h0, a[12:0]}; end
    end
    @(negedge clk);
    check({tag, " R12 ready"}, {63'h0, req_ready}, 64'd1);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check({tag, " R4/R7 fetch"}, {63'h0, mem_req_valid}, {63'h0, fetch});
    if (fetch) begin
      check({tag, " R5/R6 eaddr"}, mem_req_addr, exp_eaddr(a));
      check({tag, " R12 busy"}, {63'h0, req_ready}, 64'd0);
      @(posedge clk);
      @(negedge clk);
      check({tag, " R12 pulse"}, {63'h0, mem_req_valid}, 64'd0);
      for (int i = 0; i < lat; i++) begin
        @(posedge clk); @(negedge clk);
        check({tag, " R12 no early done"}, {63'h0, done}, 64'd0);
      end
      mem_rsp_valid = 1; mem_rsp_data = to_bus(e);             // R8
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 0;
    end
    check({tag, " done"}, {63'h0, done}, 64'd1);
    check({tag, " R11 phys"}, phys_addr, xp);
    check({tag, " R11 mask"}, page_mask, xm);
    check({tag, " R10 perm"}, {62'h0, perm}, {62'h0, xr});
  endtask

  task automatic set_ctrl(bit en, bit big, logic [2:0] code, bit halves);
    logic [63:0] c = {32'h0, 13'h0, code, 13'h0, big, 1'b0, en};
    if (halves) begin
      reg_wr(5'h00, 0, {32'h0, c[63:32]});
      reg_wr(5'h04, 0, {32'h0, c[31:0]});
    end else reg_wr(5'h00, 1, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    sh_ctrl = '0; sh_base = '0;
    rst_n = 0; reg_valid = 0; reg_write = 0; reg_size64 = 0; reg_addr = '0;
    reg_wdata = '0; req_valid = 0; req_addr = '0; mem_rsp_valid = 0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 ready", {63'h0, req_ready}, 64'd1);
    check("R1 done", {63'h0, done}, 64'd0);
    check("R1 memreq", {63'h0, mem_req_valid}, 64'd0);
    reg_chk("R1 ctrl", 5'h00, 1);
    reg_chk("R1 base", 5'h08, 1);
    xlate("R1 R4 bypass after reset", 64'hDEAD_BEEF_0123_4567, '0, 0);

    // R2 half and whole accesses
    reg_wr(5'h08, 1, 64'h1122_3344_5566_7788);
    reg_chk("R2 base whole", 5'h08, 1);
    reg_chk("R2 base upper", 5'h08, 0);
    reg_chk("R2 base lower", 5'h0C, 0);
    reg_wr(5'h08, 0, 64'hFFFF_FFFF_AAAA_0000);
    reg_chk("R2 base after upper write", 5'h08, 1);
    check("R2 upper half value", reg_rdata, 64'hAAAA_0000_5566_7788);
    reg_wr(5'h0C, 0, 64'h0000_0000_0000_8000);
    reg_chk("R2 base after lower write", 5'h08, 1);

    // R3 flush, unused and misaligned offsets
    reg_wr(5'h10, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_wr(5'h14, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_wr(5'h18, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_wr(5'h02, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_chk("R3 flush read", 5'h10, 1);
    reg_chk("R3 flush+4 read", 5'h14, 0);
    reg_chk("R3 unused read", 5'h1C, 0);
    reg_chk("R3 ctrl untouched", 5'h00, 1);
    reg_chk("R3 base untouched", 5'h08, 1);
    check("R3 base value", reg_rdata, 64'hAAAA_0000_0000_8000);
    xlate("R3 R4 still bypass", 64'h0000_0000_0000_1234, '0, 0);

    // R5 8K table, code 0 and 7 with all-ones address
    reg_wr(5'h08, 1, 64'h0000_0000_4000_0000);
    set_ctrl(1, 0, 3'd0, 0);
    xlate("R5 code0", 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0012_3002, 0);
    set_ctrl(1, 0, 3'd7, 1);
    xlate("R5 code7", 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0012_3000, 1);
    // R6 64K table code 0 and 5, big page
    set_ctrl(1, 1, 3'd0, 0);
    xlate("R6 code0", 64'hFFFF_FFFF_FFFF_FFFF, 64'hA000_01AB_CDEF_8002, 0);
    set_ctrl(1, 1, 3'd5, 0);
    xlate("R6 code5", 64'h0000_0000_FEDC_BA98, 64'hA000_0000_0003_0000, 2);
    // R7 bad codes
    set_ctrl(1, 1, 3'd6, 0);
    xlate("R7 code6", 64'h0000_0000_1234_5678, '0, 0);
    set_ctrl(1, 1, 3'd7, 1);
    xlate("R7 code7", 64'h0000_0000_1234_5678, '0, 0);
    // R8 byte order, R9 invalid, R10 read-only
    set_ctrl(1, 0, 3'd2, 0);
    xlate("R8 byte order", 64'h0000_0000_0000_0ABC, 64'h8000_0001_2345_6002, 0);
    xlate("R9 invalid", 64'h0000_0000_0000_0ABC, 64'h7FFF_FFFF_FFFF_FFFF, 0);
    xlate("R10 readonly", 64'h0000_0000_0000_0ABC, 64'h8000_0000_0000_4000, 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [63:0] a, e;
      if ($urandom_range(0, 5) == 0) begin
        set_ctrl($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)),
                 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        if ($urandom_range(0, 1) == 1)
          reg_wr(5'h08, 1, {$urandom, $urandom} & 64'h0000_0FFF_FFFF_FFF8);
      end
      a = {$urandom, $urandom};
      e = {$urandom, $urandom};
      e[63] = ($urandom_range(0, 4) != 0);
      xlate("R11 random", a, e, $urandom_range(0, 3));
    end

    repeat (2) @(negedge clk);
    report();
    $finish;
  end
endmodule